// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical page address, an access permission set and a fault code. A request carries the address, the kind of access wanted (none, read, write or execute) and whether the requester runs in user or kernel mode. The table base comes in on a separate input and is sampled when the request is accepted.

Addresses that fail the sign-extension check, and addresses inside the direct-mapped kernel window, are answered one cycle after acceptance without touching memory. Every other address is resolved by reading up to three page table entries through a single 64-bit read port with a valid/done handshake. Each walk ends in one `done` strobe; the result outputs then hold until the next `done`.

Top module: `ptw_walker`

## Requirements
- R1: A request is taken only when `busy` is low; `req_valid` while `busy` is high has no effect. `done` is a one-cycle strobe and `ok`, `fault_code`, `phys` and `perm` change only in a `done` cycle. After reset all outputs read 0.
- R2: With 43 implemented address bits, a request whose bits 63:43 are not all equal gets `fault_code` 0 (access violation) with `done` in the cycle after acceptance and no memory read.
- R3: A kernel request (`req_user`=0) with bit 63 set and bits 42:41 equal to 2'b10 completes in the cycle after acceptance with no read, `ok`=1, `perm`=3'b111 and `phys` = VA[39:0] with VA[40] placed at bit 43.
- R4: A user request to that same window gets access violation (code 0) with no read.
- R5: Walk reads go to base + index*8, with index VA[42:33], VA[32:23], VA[22:13] at levels 1, 2, 3. The first base is `tbl_base` sampled at acceptance; each later base, and the final page, is PTE[63:32] shifted left by 13.
- R6: A PTE with bit 0 (valid) clear at any level ends the walk with code 4 (translation not valid).
- R7: A valid level-1 or level-2 PTE with bit 8 (kernel read enable) clear ends the walk with code 0.
- R8: At level 3 read and execute are granted by bit 8 (kernel) or bit 9 (user), write by bit 12 (kernel) or bit 13 (user). `perm` bit 0 is read, bit 1 write, bit 2 execute. `req_acc` encodes 0 none, 1 read, 2 write, 3 execute.
- R9: If an access is requested and the level-3 grant does not include it, the result is code 0.
- R10: PTE bits 1, 2 and 3 remove read, write and execute from the grant. If the requested access is then missing, the code is 3 for execute, 2 for write, 1 for read.
- R11: A request with access type none succeeds on any valid level-3 PTE, reporting the masked grant.
- R12: `mem_rd_valid` stays high with `mem_rd_addr` stable until `mem_rd_done`; `mem_rd_data` is taken in the `mem_rd_done` cycle.
- R13: Every fault reports `ok`=0, `phys`=0 and `perm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access wanted: 0 none, 1 read, 2 write, 3 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| tbl_base | input | 64 | Level-1 table base address |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | 64 | Table entry address |
| mem_rd_done | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Table entry |
| done | output | 1 | Result strobe |
| ok | output | 1 | Translation succeeded |
| fault_code | output | 3 | 0 access violation, 1/2/3 fault-on read/write/execute, 4 not valid |
| phys | output | 64 | Physical page or window address |
| perm | output | 3 | Granted permissions: bit0 read, bit1 write, bit2 execute |

## Verification
The bench aims at the window decode edges: an address with 42:41 equal to 3 must walk, a user access to the window must fault, and a design that moved the wrong bit would report a `phys` off by bit 43. It checks that a level-3 entry denying the access outright gives an access violation before any fault-on bit is considered, so a design testing the fault-on bits first would report codes 1 to 3 instead of 0. A read with only fault-on-write set must succeed with write removed from `perm`, and an access type of none must succeed on an entry with no enables. It also changes the base input and pulses a request mid-walk; a design sampling either late would read from the wrong addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FC_ACV = 3'd0,
    FC_FOR = 3'd1,
    FC_FOW = 3'd2,
    FC_FOE = 3'd3,
    FC_TNV = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_L3   = 2'd3
  } walk_st_e;

  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_FO_LSB    = 1;
  localparam int unsigned PTE_RD_BIT    = 8;
  localparam int unsigned PTE_WR_BIT    = 12;

  function automatic logic [2:0] acc_mask(input acc_e a);
    case (a)
      ACC_READ:  return 3'b001;
      ACC_WRITE: return 3'b010;
      ACC_EXEC:  return 3'b100;
      default:   return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/ptw_vacheck.sv
module ptw_vacheck #(
  parameter int unsigned VA_IMPL_BITS = 43,
  parameter int unsigned WIN_SEL_LSB  = 41,
  parameter int unsigned WIN_SRC_BIT  = 40,
  parameter int unsigned WIN_DST_BIT  = 43
) (
  input  logic [63:0] va,
  output logic        sign_ok,
  output logic        win_hit,
  output logic [63:0] win_phys
);
  localparam int unsigned HI_W = 64 - VA_IMPL_BITS;

  logic [HI_W-1:0] hi_bits;

  always_comb begin
    hi_bits  = va[63:VA_IMPL_BITS];
    sign_ok  = (&hi_bits) | ~(|hi_bits);
    win_hit  = va[63] && (va[WIN_SEL_LSB+1:WIN_SEL_LSB] == 2'b10);
    win_phys = '0;
    win_phys[WIN_SRC_BIT-1:0] = va[WIN_SRC_BIT-1:0];
    win_phys[WIN_DST_BIT]     = va[WIN_SRC_BIT];
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 13
) (
  input  logic [63:0] pte,
  input  logic        user,
  input  acc_e        need,
  output logic [63:0] page_addr,
  output logic [2:0]  perm_out,
  output logic        fault,
  output fault_e      code
);
  logic       rd_en, wr_en;
  logic [2:0] grant, masked, need_m;
  logic       unused_pte;

  assign unused_pte = ^{pte[31:16], pte[15:14], pte[11:10], pte[7:4]};

  always_comb begin
    page_addr = 64'(pte[63:32]) << PAGE_BITS;
    rd_en     = user ? pte[PTE_RD_BIT+1] : pte[PTE_RD_BIT];
    wr_en     = user ? pte[PTE_WR_BIT+1] : pte[PTE_WR_BIT];
    grant     = {rd_en, wr_en, rd_en};
    masked    = grant & ~pte[PTE_FO_LSB+2:PTE_FO_LSB];
    need_m    = acc_mask(need);
    fault     = 1'b0;
    code      = FC_ACV;
    perm_out  = masked;
    if (!pte[PTE_VALID_BIT]) begin
      fault = 1'b1;
      code  = FC_TNV;
    end else if ((need_m != 3'b000) && ((grant & need_m) == 3'b000)) begin
      fault = 1'b1;
      code  = FC_ACV;
    end else if ((need_m != 3'b000) && ((masked & need_m) == 3'b000)) begin
      fault = 1'b1;
      if (need_m[2])      code = FC_FOE;
      else if (need_m[1]) code = FC_FOW;
      else                code = FC_FOR;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_IMPL_BITS = 43,
  parameter int unsigned PAGE_BITS    = 13,
  parameter int unsigned IDX_BITS     = 10,
  parameter int unsigned PTE_SZ_LOG2  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_va,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic [63:0] tbl_base,
  output logic        busy,
  output logic        mem_rd_valid,
  output logic [63:0] mem_rd_addr,
  input  logic        mem_rd_done,
  input  logic [63:0] mem_rd_data,
  output logic        done,
  output logic        ok,
  output logic [2:0]  fault_code,
  output logic [63:0] phys,
  output logic [2:0]  perm
);
  localparam int unsigned L3_LSB = PAGE_BITS;
  localparam int unsigned L2_LSB = PAGE_BITS + IDX_BITS;
  localparam int unsigned L1_LSB = PAGE_BITS + 2 * IDX_BITS;
  localparam int unsigned VA_TOP = L1_LSB + IDX_BITS;

  walk_st_e      state_q, state_d;
  logic [63:0]   va_q, base_q, base_d;
  logic          user_q;
  acc_e          need_q;
  logic          done_d, ok_q, ok_d;
  fault_e        fc_q, fc_d;
  logic [63:0]   phys_q, phys_d;
  logic [2:0]    perm_q, perm_d;
  logic          accept;
  logic [IDX_BITS-1:0] idx;

  logic          sign_ok, win_hit;
  logic [63:0]   win_phys;
  logic [63:0]   leaf_page;
  logic [2:0]    leaf_perm;
  logic          leaf_fault;
  fault_e        leaf_code;
  logic          unused_va;

  assign unused_va = ^{va_q[63:VA_TOP], va_q[L3_LSB-1:0]};

  ptw_vacheck #(.VA_IMPL_BITS(VA_IMPL_BITS)) u_vachk (
    .va(req_va), .sign_ok(sign_ok), .win_hit(win_hit), .win_phys(win_phys)
  );

  ptw_leaf #(.PAGE_BITS(PAGE_BITS)) u_leaf (
    .pte(mem_rd_data), .user(user_q), .need(need_q),
    .page_addr(leaf_page), .perm_out(leaf_perm),
    .fault(leaf_fault), .code(leaf_code)
  );

  assign accept       = (state_q == ST_IDLE) && req_valid;
  assign busy         = (state_q != ST_IDLE);
  assign mem_rd_valid = busy;

  always_comb begin
    case (state_q)
      ST_L1:   idx = va_q[L1_LSB +: IDX_BITS];
      ST_L2:   idx = va_q[L2_LSB +: IDX_BITS];
      default: idx = va_q[L3_LSB +: IDX_BITS];
    endcase
    mem_rd_addr = base_q + (64'(idx) << PTE_SZ_LOG2);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    done_d  = 1'b0;
    ok_d    = 1'b0;
    fc_d    = FC_ACV;
    phys_d  = '0;
    perm_d  = '0;
    case (state_q)
      ST_IDLE: begin
        base_d = tbl_base;
        if (req_valid) begin
          if (!sign_ok) begin
            done_d = 1'b1;
          end else if (win_hit) begin
            done_d = 1'b1;
            if (!req_user) begin
              ok_d   = 1'b1;
              phys_d = win_phys;
              perm_d = 3'b111;
            end
          end else begin
            state_d = ST_L1;
          end
        end
      end
      ST_L1, ST_L2: begin
        if (mem_rd_done) begin
          if (!mem_rd_data[PTE_VALID_BIT]) begin
            done_d  = 1'b1;
            fc_d    = FC_TNV;
            state_d = ST_IDLE;
          end else if (!mem_rd_data[PTE_RD_BIT]) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            base_d  = leaf_page;
            state_d = (state_q == ST_L1) ? ST_L2 : ST_L3;
          end
        end
      end
      default: begin
        if (mem_rd_done) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
          if (leaf_fault) begin
            fc_d = leaf_code;
          end else begin
            ok_d   = 1'b1;
            phys_d = leaf_page;
            perm_d = leaf_perm;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      user_q  <= 1'b0;
      need_q  <= ACC_NONE;
      done    <= 1'b0;
      ok_q    <= 1'b0;
      fc_q    <= FC_ACV;
      phys_q  <= '0;
      perm_q  <= '0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (accept) begin
        va_q   <= req_va;
        user_q <= req_user;
        need_q <= acc_e'(req_acc);
      end
      if (accept || (busy && mem_rd_done)) begin
        base_q <= base_d;
      end
      if (done_d) begin
        ok_q   <= ok_d;
        fc_q   <= fc_d;
        phys_q <= phys_d;
        perm_q <= perm_d;
      end
    end
  end

  assign ok         = ok_q;
  assign fault_code = fc_q;
  assign phys       = phys_q;
  assign perm       = perm_q;

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ok) && $stable(fault_code) && $stable(phys) && $stable(perm)));

  assert_ok_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && (need_q != ACC_NONE)) |-> ((perm & acc_mask(need_q)) != 3'b000));

  assert_fault_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> ((phys == 64'd0) && (perm == 3'b000)));
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_user, mem_rd_done;
  logic [63:0] req_va, tbl_base, mem_rd_data;
  logic [1:0]  req_acc;
  logic        busy, mem_rd_valid, done, ok;
  logic [63:0] mem_rd_addr, phys;
  logic [2:0]  fault_code, perm;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mem [logic [63:0]];
  localparam logic [63:0] BASE = 64'h0010_0000;
  localparam logic [63:0] L2T  = 64'h0040_0000;
  localparam logic [63:0] L3T  = 64'h0060_0000;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_acc(req_acc), .req_user(req_user), .tbl_base(tbl_base),
    .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data), .done(done),
    .ok(ok), .fault_code(fault_code), .phys(phys), .perm(perm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] pte(input logic [31:0] pfn, input logic [15:0] fl);
    return {pfn, 16'h0, fl};
  endfunction

  function automatic logic [63:0] mkva(input int l1, input int l2, input int l3, input int off);
    return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(off);
  endfunction

  // behavioural reference walk
  function automatic void model(input logic [63:0] va, input logic [1:0] acc, input bit user,
                                input logic [63:0] b0,
                                output bit e_ok, output logic [2:0] e_fc,
                                output logic [63:0] e_phys, output logic [2:0] e_perm,
                                output int n, output logic [63:0] addrs [3]);
    logic [63:0] base, a, p;
    int needm, prot, r, w;
    e_ok = 0; e_fc = 0; e_phys = 0; e_perm = 0; n = 0;
    for (int k = 0; k < 3; k++) addrs[k] = 0;
    if (($signed(va) >>> 43) != ($signed(va) >>> 63)) return;
    if (va[63] && (((va >> 41) & 64'd3) == 64'd2)) begin
      if (user) return;
      e_ok = 1; e_perm = 3'b111;
      e_phys = (va & ((64'd1 << 40) - 1)) | ((va & (64'd1 << 40)) << 3);
      return;
    end
    base = b0;
    for (int lvl = 0; lvl < 3; lvl++) begin
      a = base + (((va >> (13 + 10 * (2 - lvl))) & 64'd1023) * 8);
      addrs[n] = a; n++;
      p = rd(a);
      if (p[0] == 1'b0) begin e_fc = 4; return; end
      if (lvl < 2) begin
        if (p[8] == 1'b0) return;
        base = (p >> 32) << 13;
      end else begin
        r = int'(p[8 + int'(user)]);
        w = int'(p[12 + int'(user)]);
        prot  = (r != 0 ? 5 : 0) | (w != 0 ? 2 : 0);
        needm = (acc == 0) ? 0 : (acc == 1) ? 1 : (acc == 2) ? 2 : 4;
        if (needm != 0 && (prot & needm) == 0) return;
        prot = prot & ~int'((p >> 1) & 64'd7);
        if (needm != 0 && (prot & needm) == 0) begin
          e_fc = (needm == 4) ? 3 : (needm == 2) ? 2 : 1;
          return;
        end
        e_ok = 1; e_phys = (p >> 32) << 13; e_perm = 3'(prot);
      end
    end
  endfunction

  task automatic run(input string rq, input logic [63:0] va, input logic [1:0] acc,
                     input bit user, input int lat, input bit poke);
    bit e_ok; logic [2:0] e_fc, e_perm; logic [63:0] e_phys; int n;
    logic [63:0] addrs [3];
    model(va, acc, user, tbl_base, e_ok, e_fc, e_phys, e_perm, n, addrs);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user;
    @(negedge clk);
    req_valid = 1'b0; req_va = ~va; req_acc = ~acc; req_user = ~user;
    tbl_base = 64'h00DE_AD00_0000;
    for (int i = 0; i < n; i++) begin
      chk(rq, "busy", 64'(busy), 64'd1);
      chk(rq, "done_mid", 64'(done), 64'd0);
      chk("R5", "rd_addr", mem_rd_addr, addrs[i]);
      for (int c = 0; c < lat; c++) begin
        if (poke && i == 0 && c == 0) begin
          req_valid = 1'b1; req_va = mkva(2, 0, 0, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "rd_valid_hold", 64'(mem_rd_valid), 64'd1);
        chk("R12", "rd_addr_hold", mem_rd_addr, addrs[i]);
      end
      mem_rd_done = 1'b1; mem_rd_data = rd(addrs[i]);
      @(negedge clk);
      mem_rd_done = 1'b0; mem_rd_data = 64'hFFFF_FFFF_FFFF_FFFF;
    end
    chk(rq, "done", 64'(done), 64'd1);
    chk(rq, "busy_end", 64'(busy), 64'd0);
    chk(rq, "ok", 64'(ok), 64'(e_ok));
    chk(rq, "fault_code", 64'(fault_code), 64'(e_fc));
    chk(rq, "phys", phys, e_phys);
    chk(rq, "perm", 64'(perm), 64'(e_perm));
    @(negedge clk);
    chk("R1", "done_strobe", 64'(done), 64'd0);
    chk("R1", "hold_phys", phys, e_phys);
    chk("R1", "hold_code", 64'(fault_code), 64'(e_fc));
    tbl_base = BASE;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // tables: V=1 FOR=2 FOW=4 FOE=8 KRE=100 URE=200 KWE=1000 UWE=2000
    mem[BASE + 8*1]     = pte(32'h200, 16'h0101);
    mem[BASE + 8*3]     = pte(32'h201, 16'h0001);
    mem[BASE + 8*12'h301] = pte(32'h200, 16'h0101);
    mem[L2T + 8*7]      = pte(32'h300, 16'h0101);
    mem[L2T + 8*8]      = pte(32'h301, 16'h0001);
    mem[L3T + 8*0]      = pte(32'h12345, 16'h1101);
    mem[L3T + 8*1]      = pte(32'h11111, 16'h0101);
    mem[L3T + 8*2]      = pte(32'h22222, 16'h2201);
    mem[L3T + 8*3]      = pte(32'h33333, 16'h0103);
    mem[L3T + 8*4]      = pte(32'h44444, 16'h1105);
    mem[L3T + 8*5]      = pte(32'h55555, 16'h0109);
    mem[L3T + 8*7]      = pte(32'h66666, 16'h0001);
    mem[L3T + 8*8]      = pte(32'hABCDE, 16'h1105);
    mem[L3T + 8*9]      = pte(32'h77777, 16'h0001);

    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_acc = '0; req_user = 1'b0;
    tbl_base = BASE; mem_rd_done = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rst_done", 64'(done), 64'd0);
    chk("R1", "rst_busy", 64'(busy), 64'd0);
    chk("R1", "rst_rd_valid", 64'(mem_rd_valid), 64'd0);
    chk("R1", "rst_ok", 64'(ok), 64'd0);
    chk("R1", "rst_code", 64'(fault_code), 64'd0);
    chk("R1", "rst_phys", phys, 64'd0);
    chk("R1", "rst_perm", 64'(perm), 64'd0);

    run("R8",  mkva(1, 7, 0, 16'h123), 2'd1, 1'b0, 0, 1'b0);
    run("R1",  mkva(1, 7, 0, 0),       2'd2, 1'b0, 3, 1'b1);
    run("R9",  mkva(1, 7, 1, 0),       2'd1, 1'b1, 1, 1'b0);
    run("R8",  mkva(1, 7, 2, 0),       2'd2, 1'b1, 2, 1'b0);
    run("R9",  mkva(1, 7, 2, 0),       2'd2, 1'b0, 0, 1'b0);
    run("R6",  mkva(2, 0, 0, 0),       2'd1, 1'b0, 1, 1'b0);
    run("R7",  mkva(3, 0, 0, 0),       2'd1, 1'b0, 0, 1'b0);
    run("R7",  mkva(1, 8, 0, 0),       2'd1, 1'b0, 1, 1'b0);
    run("R6",  mkva(1, 9, 0, 0),       2'd1, 1'b0, 0, 1'b0);
    run("R6",  mkva(1, 7, 6, 0),       2'd3, 1'b0, 2, 1'b0);
    run("R10", mkva(1, 7, 3, 0),       2'd1, 1'b0, 0, 1'b0);
    run("R10", mkva(1, 7, 4, 0),       2'd2, 1'b0, 1, 1'b0);
    run("R10", mkva(1, 7, 5, 0),       2'd3, 1'b0, 0, 1'b0);
    run("R10", mkva(1, 7, 8, 0),       2'd1, 1'b0, 0, 1'b0);
    run("R9",  mkva(1, 7, 9, 0),       2'd3, 1'b0, 0, 1'b0);
    run("R11", mkva(1, 7, 7, 0),       2'd0, 1'b1, 1, 1'b0);
    run("R13", mkva(1, 7, 1, 0),       2'd2, 1'b0, 0, 1'b0);
    run("R3",  64'hFFFF_FD12_3456_7890, 2'd2, 1'b0, 0, 1'b0);
    run("R3",  64'hFFFF_FC00_0000_2000, 2'd3, 1'b0, 0, 1'b0);
    run("R4",  64'hFFFF_FD12_3456_7890, 2'd1, 1'b1, 0, 1'b0);
    run("R2",  64'h0000_0800_0000_0000, 2'd1, 1'b0, 0, 1'b0);
    run("R2",  64'h7FFF_F800_0000_0000, 2'd0, 1'b0, 0, 1'b0);
    run("R5",  64'hFFFF_FE00_0000_0000 | mkva(1, 7, 0, 16'h10), 2'd1, 1'b0, 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule